// File: doc/BRIEF.md
# Mode-Configurable Depth Byte FIFO

This block is the byte queue behind one direction of a serial channel. It always owns 128 bytes of storage, but the depth it uses is chosen at run time. The choice depends on a queue-enable bit, a board strap, an enhanced-mode bit, and a guarded large-queue bit that the block holds itself. A producer pushes bytes and a consumer pops them. The block reports a fill count, full and empty flags, an overrun pulse for a dropped push, and a trigger flag.

The trigger flag compares the fill count with a threshold. The threshold comes either from a four-entry fixed table or from a free 8-bit value. Any change of the selected depth empties the queue, so the pointers never point past the new depth.

Top module: `mode_depth_fifo`

## Requirements
- R1: After a synchronous reset, `empty_o`=1, `full_o`=0, `level_o`=0, `trig_o`=0, `overrun_o`=0 and `big_bit_o`=0.
- R2: When `fifo_en_i` is 0, the depth is 1 byte. `strap_small_i`, `enh_mode_i` and `big_bit_o` have no effect on the depth, and changing them causes no flush.
- R3: With `fifo_en_i`=1, `enh_mode_i`=0, `big_bit_o`=0 and `strap_small_i`=1, the depth is 16.
- R4: With `fifo_en_i`=1 and `strap_small_i`=0, the depth is 128.
- R5: The large-queue bit (`big_bit_o`) takes `big_val_i` on a clock edge where `big_wr_i`=1, but only if `guard_i`=1 in that cycle; otherwise it is unchanged. While it is 1 and `fifo_en_i`=1, the depth is 128 whatever the strap.
- R6: With `enh_mode_i`=1 and `fifo_en_i`=1, the depth is 128 whatever the strap.
- R7: Bytes leave in the order they arrived. A pop on a non-empty queue puts the oldest byte on `pop_data_o` one cycle later. A pop on an empty queue is ignored and `pop_data_o` holds its value.
- R8: After each edge, `level_o` equals the number of stored bytes (0 to 128). `full_o` is 1 exactly when `level_o` equals the depth, and `empty_o` is 1 exactly when `level_o` is 0.
- R9: A push seen while the queue holds depth bytes is dropped, even if a pop occurs in the same cycle. The next cycle, `overrun_o` is high for one cycle.
- R10: In a cycle where the configuration inputs select a depth that differs from the one in use, the queue is emptied at the clock edge. Any push or pop in that cycle is discarded and raises no overrun.
- R11: With `arb_trig_en_i`=1, `trig_o` is 1 when `level_o` ≥ `arb_thr_i`. A threshold of 0 acts as 1.
- R12: With `arb_trig_en_i`=0, the threshold comes from `fixed_sel_i`: 0→1, 1→4, 2→8, 3→14. `trig_o` is 1 when `level_o` ≥ that threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en_i | input | 1 | Queue enable; 0 selects single-byte mode |
| strap_small_i | input | 1 | Board strap; 1 requests the 16-byte depth |
| enh_mode_i | input | 1 | Enhanced mode; forces 128 when enabled |
| guard_i | input | 1 | Write guard for the large-queue bit |
| big_wr_i | input | 1 | Write strobe for the large-queue bit |
| big_val_i | input | 1 | Value written to the large-queue bit |
| push_i | input | 1 | Push strobe |
| push_data_i | input | DATA_W | Byte to push |
| pop_i | input | 1 | Pop strobe |
| arb_trig_en_i | input | 1 | Selects the free 8-bit threshold |
| arb_thr_i | input | 8 | Free threshold value |
| fixed_sel_i | input | 2 | Fixed threshold table index |
| pop_data_o | output | DATA_W | Popped byte, valid the cycle after the pop |
| full_o | output | 1 | Level equals the depth in use |
| empty_o | output | 1 | Level is zero |
| level_o | output | LVL_W | Stored byte count |
| trig_o | output | 1 | Level at or above the threshold |
| overrun_o | output | 1 | One-cycle pulse for a dropped push |
| big_bit_o | output | 1 | Current large-queue bit |

## Verification
The bench works through every depth-selection priority and checks each one by where `full_o` rises. A design that let the strap override enhanced mode or the guarded bit would show full at 16 instead of 128. The bench writes the guarded bit with the guard low; a design that accepted that write would lose its queued bytes through a flush. It changes configuration while bytes are queued, where a missing flush leaves stale data and a wrong level. It also pushes into a full queue while popping from it, and sets the free threshold to zero, where an off-by-one or an unguarded compare shows up at once.

// File: rtl/fifo_cfg_pkg.sv
package fifo_cfg_pkg;
  localparam int THR_W = 8;

  typedef enum logic [1:0] {
    TRIG_ONE      = 2'd0,
    TRIG_FOUR     = 2'd1,
    TRIG_EIGHT    = 2'd2,
    TRIG_FOURTEEN = 2'd3
  } fixed_trig_e;

  function automatic logic [THR_W-1:0] fixed_level(input fixed_trig_e sel);
    case (sel)
      TRIG_ONE:      return THR_W'(1);
      TRIG_FOUR:     return THR_W'(4);
      TRIG_EIGHT:    return THR_W'(8);
      default:       return THR_W'(14);
    endcase
  endfunction
endpackage

// File: rtl/fifo_depth_sel.sv
module fifo_depth_sel #(
  parameter int LVL_W     = 8,
  parameter int DEPTH_MAX = 128,
  parameter int DEPTH_MID = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic             strap_small,
  input  logic             enh,
  input  logic             guard,
  input  logic             big_wr,
  input  logic             big_val,
  output logic [LVL_W-1:0] depth_now,
  output logic             big_q
);
  // guarded large-queue bit
  always_ff @(posedge clk) begin
    if (rst)                  big_q <= 1'b0;
    else if (big_wr && guard) big_q <= big_val;
  end

  // depth priority: enable, then any 128 request, then strap
  always_comb begin
    if (!fifo_en)                       depth_now = LVL_W'(1);
    else if (enh || big_q || !strap_small) depth_now = LVL_W'(DEPTH_MAX);
    else                                depth_now = LVL_W'(DEPTH_MID);
  end

  assert_guard_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (big_wr && !guard) |=> $stable(big_q));
endmodule

// File: rtl/fifo_thresh.sv
module fifo_thresh
  import fifo_cfg_pkg::*;
(
  input  logic             arb_en,
  input  logic [THR_W-1:0] arb_thr,
  input  logic [1:0]       fixed_sel,
  output logic [THR_W-1:0] thr_eff
);
  always_comb begin
    if (arb_en) thr_eff = (arb_thr == '0) ? THR_W'(1) : arb_thr;
    else        thr_eff = fixed_level(fixed_trig_e'(fixed_sel));
  end
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mode_depth_fifo.sv
module mode_depth_fifo
  import fifo_cfg_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH_MAX = 128,
  parameter int DEPTH_MID = 16,
  parameter int LVL_W     = $clog2(DEPTH_MAX) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en_i,
  input  logic              strap_small_i,
  input  logic              enh_mode_i,
  input  logic              guard_i,
  input  logic              big_wr_i,
  input  logic              big_val_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              arb_trig_en_i,
  input  logic [7:0]        arb_thr_i,
  input  logic [1:0]        fixed_sel_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              trig_o,
  output logic              overrun_o,
  output logic              big_bit_o
);
  localparam int AW    = $clog2(DEPTH_MAX);
  localparam int CMP_W = ((LVL_W > THR_W) ? LVL_W : THR_W) + 1;

  logic [LVL_W-1:0] depth_now, depth_q, count, count_n;
  logic [AW-1:0]    wr_ptr, rd_ptr, mask;
  logic [THR_W-1:0] thr_eff;
  logic             flush, do_push, do_pop;

  fifo_depth_sel #(.LVL_W(LVL_W), .DEPTH_MAX(DEPTH_MAX), .DEPTH_MID(DEPTH_MID)) u_sel (
    .clk(clk), .rst(rst), .fifo_en(fifo_en_i), .strap_small(strap_small_i),
    .enh(enh_mode_i), .guard(guard_i), .big_wr(big_wr_i), .big_val(big_val_i),
    .depth_now(depth_now), .big_q(big_bit_o));

  fifo_thresh u_thr (
    .arb_en(arb_trig_en_i), .arb_thr(arb_thr_i), .fixed_sel(fixed_sel_i),
    .thr_eff(thr_eff));

  fifo_ram #(.DW(DATA_W), .AW(AW)) u_ram (
    .clk(clk), .we(do_push), .waddr(wr_ptr), .wdata(push_data_i),
    .re(do_pop), .raddr(rd_ptr), .rdata(pop_data_o));

  always_comb begin
    flush   = (depth_now != depth_q);
    mask    = AW'(depth_q - LVL_W'(1));
    do_pop  = pop_i && (count != '0) && !flush;
    do_push = push_i && (count < depth_q) && !flush;
    if (flush) count_n = '0;
    else       count_n = count + LVL_W'(do_push) - LVL_W'(do_pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q   <= LVL_W'(1);
      count     <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      full_o    <= 1'b0;
      empty_o   <= 1'b1;
      trig_o    <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      depth_q <= depth_now;
      count   <= count_n;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (do_push) wr_ptr <= (wr_ptr + 1'b1) & mask;
        if (do_pop)  rd_ptr <= (rd_ptr + 1'b1) & mask;
      end
      full_o    <= (count_n == depth_now);
      empty_o   <= (count_n == '0);
      trig_o    <= (CMP_W'(count_n) >= CMP_W'(thr_eff));
      overrun_o <= push_i && !flush && !do_push;
    end
  end

  assign level_o = count;

  assert_level_bound_R8: assert property (@(posedge clk) disable iff (rst)
    level_o <= depth_q);
  assert_full_empty_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(full_o && empty_o));
  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (rst)
    overrun_o |-> $past(push_i && full_o));
  assert_byte_mode_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(fifo_en_i) |-> (level_o <= LVL_W'(1)));
  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(depth_now) != $past(depth_q)) |-> empty_o);
endmodule

// File: tb/test_mode_depth_fifo.sv
module test_mode_depth_fifo;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fen = 0, strap = 1, enh = 0, guard = 0, bwr = 0, bval = 0;
  logic push = 0, pop = 0, arb = 0;
  logic [7:0] pdata = 0, thr = 0;
  logic [1:0] fsel = 0;
  logic [7:0] pop_data, level;
  logic full, empty, trig, ovr, bigb;

  int nchk = 0, nfail = 0;
  byte unsigned q[$];
  int depth_m = 1;
  bit big_m = 0, ovr_m = 0, pend = 0;
  byte unsigned exp_data = 0;
  int dcnt = 1;

  always #10 clk = ~clk;

  mode_depth_fifo i_mode_depth_fifo (
    .clk(clk), .rst(rst), .fifo_en_i(fen), .strap_small_i(strap), .enh_mode_i(enh),
    .guard_i(guard), .big_wr_i(bwr), .big_val_i(bval), .push_i(push),
    .push_data_i(pdata), .pop_i(pop), .arb_trig_en_i(arb), .arb_thr_i(thr),
    .fixed_sel_i(fsel), .pop_data_o(pop_data), .full_o(full), .empty_o(empty),
    .level_o(level), .trig_o(trig), .overrun_o(ovr), .big_bit_o(bigb));

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int thr_m();
    if (arb) return (thr == 0) ? 1 : int'(thr);
    case (fsel)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic model();
    int dn;
    bit pu, po;
    dn = !fen ? 1 : ((enh || big_m || !strap) ? 128 : 16);
    pend = 0;
    if (dn != depth_m) begin
      q.delete();
      depth_m = dn;
      ovr_m = 0;
    end else begin
      pu = push && (q.size() < depth_m);
      po = pop && (q.size() > 0);
      ovr_m = push && !pu;
      if (po) begin exp_data = q.pop_front(); pend = 1; end
      if (pu) q.push_back(pdata);
    end
    if (bwr && guard) big_m = bval;
  endtask

  task automatic compare();
    chk("R8 level", level, q.size());
    chk("R8 full", full, q.size() == depth_m);
    chk("R8 empty", empty, q.size() == 0);
    chk("R9 overrun", ovr, ovr_m);
    chk("R5 bit", bigb, big_m);
    chk(arb ? "R11 trig" : "R12 trig", trig, q.size() >= thr_m());
    if (pend) chk("R7 data", pop_data, exp_data);
  endtask

  task automatic cycle();
    model();
    @(posedge clk);
    @(negedge clk);
    compare();
    push = 0; pop = 0; bwr = 0;
  endtask

  task automatic push_n(int n);
    for (int i = 0; i < n; i++) begin
      push = 1; pdata = 8'(dcnt); dcnt++;
      cycle();
    end
  endtask

  task automatic pop_n(int n);
    for (int i = 0; i < n; i++) begin
      pop = 1;
      cycle();
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset values
    chk("R1 empty", empty, 1); chk("R1 full", full, 0); chk("R1 level", level, 0);
    chk("R1 trig", trig, 0); chk("R1 overrun", ovr, 0); chk("R1 bit", bigb, 0);

    // R2 byte mode, other selectors ignored
    fen = 0; strap = 0; enh = 1;
    cycle();
    push_n(1);
    chk("R2 full at one", full, 1);
    push_n(1);
    chk("R9 overrun in byte mode", ovr, 1);
    strap = 1; enh = 0; cycle();
    chk("R2 no flush on strap change", level, 1);
    pop_n(1);
    chk("R7 byte mode data", pop_data, dcnt - 2);

    // R3 depth 16
    fen = 1; strap = 1; enh = 0;
    cycle();
    push_n(15);
    chk("R3 not full at 15", full, 0);
    push_n(1);
    chk("R3 full at 16", full, 1);
    push = 1; pop = 1; pdata = 8'hAA; cycle();
    chk("R9 push+pop when full drops push", ovr, 1);
    pop_n(3);
    pop = 1; push = 1; pdata = 8'h55; cycle();
    pop_n(14);
    pop_n(2);
    chk("R7 pop empty ignored", empty, 1);

    // R10 flush on config change while holding data
    push_n(5);
    strap = 0; push = 1; pdata = 8'h11; cycle();
    chk("R10 flushed", level, 0);
    chk("R10 no overrun on flush", ovr, 0);

    // R4 depth 128
    push_n(127);
    chk("R4 not full at 127", full, 0);
    push_n(1);
    chk("R4 full at 128", full, 1);
    chk("R8 level 128", level, 128);
    pop_n(128);

    // R5 guarded bit
    strap = 1; cycle();
    push_n(3);
    bwr = 1; bval = 1; guard = 0; cycle();
    chk("R5 unguarded write ignored", bigb, 0);
    cycle();
    chk("R5 no flush after ignored write", level, 3);
    guard = 1; bwr = 1; bval = 1; cycle();
    chk("R5 guarded write taken", bigb, 1);
    cycle();
    push_n(20);
    chk("R5 depth 128 with bit", full, 0);
    chk("R5 level beyond 16", level, 20);
    pop_n(20);

    // R6 enhanced mode
    bwr = 1; bval = 0; cycle();
    guard = 0; cycle();
    enh = 1; cycle();
    push_n(17);
    chk("R6 enhanced gives 128", full, 0);
    pop_n(17);
    enh = 0; cycle();

    // R11 free threshold, R12 fixed table
    arb = 1; thr = 0; cycle();
    push_n(1);
    chk("R11 zero threshold acts as one", trig, 1);
    thr = 5; cycle();
    chk("R11 below threshold", trig, 0);
    push_n(4);
    chk("R11 at threshold", trig, 1);
    arb = 0; fsel = 2; cycle();
    chk("R12 level 5 below 8", trig, 0);
    fsel = 1; cycle();
    chk("R12 level 5 above 4", trig, 1);
    fsel = 3; push_n(9);
    chk("R12 level 14 meets 14", trig, 1);
    pop_n(14);

    summary();
    $finish;
  end
endmodule